// File: doc/BRIEF.md
# Eight-Line Prioritizing Interrupt Controller

This block gathers eight device request lines, screens them with one mask bit per line and ranks the survivors by fixed priority. It raises a single interrupt toward the CPU. The CPU answers with two low pulses on an active-low acknowledge line. The first pulse makes the controller drop its interrupt output, pick the winning line and mark it as in service. During the second pulse the controller places the winning vector on an 8-bit data bus and asserts a bus-drive enable. The vector is the line number added to a programmable base. The base resets to 32, so vectors below 32 are never produced.

Line 0 carries the interval timer and has the highest priority. Line 7 has the lowest. Line 2 is reserved for a second controller's request and is treated as an ordinary request line. A line in service holds off its own level and every lower level until software writes an end-of-interrupt. Such a line still lets a higher level interrupt, so handlers can nest. A small register port with a 2-bit address gives access to the mask, the base, the in-service bits and the sampled requests.

Top module: `irq_ctl`

## Requirements
- R1: After a synchronous active-low reset, the following hold: `intr_o`=0, `data_oe_o`=0 and `data_o`=0. Reading the registers gives mask 0x00, base 0x20 and in-service 0x00.
- R2: A line whose mask bit is 1 (register address 0, bit n = line n) never causes `intr_o` to rise. When every pending line is masked, `intr_o` stays 0.
- R3: `intr_o` rises in the cycle after an unmasked, unblocked request is sampled. The lowest-numbered eligible line wins, and its vector is base + line number.
- R4: `intr_o` is 0 while `inta_n_i` is low. It stays 0 from the first acknowledge pulse until the second pulse ends.
- R5: When the first pulse is sampled, the winner's bit in the in-service register (address 2, bit n = line n) is set. An in-service line blocks itself and all higher-numbered lines, but lower-numbered lines can still interrupt.
- R6: A write to address 2 is an end-of-interrupt. Every in-service bit whose write-data bit is 1 is cleared.
- R7: `data_oe_o` is 1 only while `inta_n_i` is low during the second pulse. At every other time, `data_o` is 0.
- R8: A write of the base (address 1) takes effect only for values from 32 to 248. Any other value leaves the base unchanged.
- R9: If no line is eligible when the first pulse is sampled, the sequence still completes. It delivers base + 7 and sets no in-service bit.
- R10: Address 3 reads the request register, which holds the request lines as sampled on the previous clock. Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | 8 | Level-sensitive device requests; bit 0 timer, bit 2 cascade |
| inta_n_i | input | 1 | Active-low acknowledge from the CPU |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 mask, 1 base, 2 in-service/EOI, 3 requests |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| intr_o | output | 1 | Interrupt request to the CPU |
| data_o | output | 8 | Vector bus, zero when not driven |
| data_oe_o | output | 1 | Vector bus drive enable |

## Verification
The priority logic is tried with four input patterns:
- A single request. This shows that the vector is formed as base + line number.
- Two simultaneous requests. This shows the fixed ordering, because line 2 must beat line 5.
- A higher line arriving while a lower one is in service. This separates correct nesting from plain blocking.
- All lines pending under a partial mask. This shows that masked lines are removed before ranking, not after it.

An acknowledge with nothing pending tests the fallback vector, and the end-of-interrupt writes show that in-service blocking is released bit by bit. Every delivered vector passes through a scoreboard queue. On every other cycle the bus is checked to be zero.

// File: rtl/irq_ctl_pkg.sv
`timescale 1ns/1ps
// Package: shared state type and register address codes for irq_ctl.
package irq_ctl_pkg;
    // Acknowledge sequence states: waiting, first pulse low, gap, second pulse low.
    typedef enum logic [1:0] {
        ACK_IDLE   = 2'd0,
        ACK_FIRST  = 2'd1,
        ACK_GAP    = 2'd2,
        ACK_SECOND = 2'd3
    } ack_state_t;

    // Register port address codes.
    localparam logic [1:0] ADDR_MASK = 2'd0;
    localparam logic [1:0] ADDR_BASE = 2'd1;
    localparam logic [1:0] ADDR_ISR  = 2'd2;
    localparam logic [1:0] ADDR_REQ  = 2'd3;
endpackage

// File: rtl/irq_regs.sv
`timescale 1ns/1ps
// Module: irq_regs
// Holds the sampled request lines, the per-line mask, the vector base and the
// in-service bits, and serves the register read/write port.
// Assumes VW >= N so that one data word covers all lines.
module irq_regs #(
    parameter int N        = 8,
    parameter int VW       = 8,
    parameter int BASE_RST = 32,
    parameter int BASE_MIN = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_i,
    input  logic          reg_we_i,
    input  logic [1:0]    reg_addr_i,
    input  logic [VW-1:0] reg_wdata_i,
    input  logic [N-1:0]  isr_set_i,
    output logic [N-1:0]  req_q,
    output logic [N-1:0]  mask_q,
    output logic [VW-1:0] base_q,
    output logic [N-1:0]  isr_q,
    output logic [VW-1:0] reg_rdata_o
);
    import irq_ctl_pkg::*;

    localparam int BASE_MAX = (1 << VW) - N;

    logic          wr_mask, wr_base, wr_eoi, base_ok;
    logic [N-1:0]  eoi_clr;

    // Decode which register a write targets and whether a new base is in range.
    always_comb begin
        wr_mask = reg_we_i && (reg_addr_i == ADDR_MASK);
        wr_base = reg_we_i && (reg_addr_i == ADDR_BASE);
        wr_eoi  = reg_we_i && (reg_addr_i == ADDR_ISR);
        base_ok = (int'(reg_wdata_i) >= BASE_MIN) && (int'(reg_wdata_i) <= BASE_MAX);
        eoi_clr = wr_eoi ? reg_wdata_i[N-1:0] : '0;
    end

    // Sample the level-sensitive request lines every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= irq_i;
    end

    // Mask and base registers, base writes outside the legal range dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            base_q <= VW'(BASE_RST);
        end else begin
            if (wr_mask)            mask_q <= reg_wdata_i[N-1:0];
            if (wr_base && base_ok) base_q <= reg_wdata_i;
        end
    end

    // In-service bits: set by acknowledge, cleared by end-of-interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= (isr_q | isr_set_i) & ~eoi_clr;
    end

    // Read multiplexer for the register port.
    always_comb begin
        unique case (reg_addr_i)
            ADDR_MASK: reg_rdata_o = VW'(mask_q);
            ADDR_BASE: reg_rdata_o = base_q;
            ADDR_ISR:  reg_rdata_o = VW'(isr_q);
            default:   reg_rdata_o = VW'(req_q);
        endcase
    end
endmodule

// File: rtl/irq_prio.sv
`timescale 1ns/1ps
// Module: irq_prio
// Fixed-priority resolver: line 0 highest. A line is eligible when pending and
// no in-service bit at its own or a higher level is set. Purely combinational.
module irq_prio #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  pend_i,
    input  logic [N-1:0]  isr_i,
    output logic          win_valid_o,
    output logic [IW-1:0] win_idx_o
);
    logic [N-1:0] allowed;
    logic [N-1:0] cand;

    // Each level is open only while no equal or higher level is in service.
    for (genvar i = 0; i < N; i++) begin : g_open
        assign allowed[i] = ~|isr_i[i:0];
    end

    assign cand = pend_i & allowed;

    // Pick the lowest-numbered candidate.
    always_comb begin
        win_valid_o = 1'b0;
        win_idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                win_valid_o = 1'b1;
                win_idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_ack_fsm.sv
`timescale 1ns/1ps
// Module: irq_ack_fsm
// Follows the two-pulse acknowledge, drives the interrupt request, latches
// the winner on the first pulse and drives the vector during the second.
// Assumes inta_n_i is synchronous to clk and each pulse lasts at least a cycle.
module irq_ack_fsm #(
    parameter int N  = 8,
    parameter int VW = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inta_n_i,
    input  logic          win_valid_i,
    input  logic [IW-1:0] win_idx_i,
    input  logic [VW-1:0] base_i,
    output logic          intr_o,
    output logic [N-1:0]  isr_set_o,
    output logic [VW-1:0] data_o,
    output logic          data_oe_o
);
    import irq_ctl_pkg::*;

    ack_state_t    st_q, st_d;
    logic [IW-1:0] lock_q;
    logic          start;

    assign start = (st_q == ACK_IDLE) && !inta_n_i;

    // Next-state logic driven by the level of the acknowledge line.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ACK_IDLE:   if (!inta_n_i) st_d = ACK_FIRST;
            ACK_FIRST:  if (inta_n_i)  st_d = ACK_GAP;
            ACK_GAP:    if (!inta_n_i) st_d = ACK_SECOND;
            ACK_SECOND: if (inta_n_i)  st_d = ACK_IDLE;
            default:    st_d = ACK_IDLE;
        endcase
    end

    // State and latched winner; no winner falls back to the lowest level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ACK_IDLE;
            lock_q <= '0;
        end else begin
            st_q <= st_d;
            if (start) lock_q <= win_valid_i ? win_idx_i : IW'(N - 1);
        end
    end

    // Request output, in-service set pulse and vector bus.
    always_comb begin
        intr_o    = (st_q == ACK_IDLE) && inta_n_i && win_valid_i;
        isr_set_o = (start && win_valid_i) ? (N'(1) << win_idx_i) : '0;
        data_oe_o = ((st_q == ACK_GAP) || (st_q == ACK_SECOND)) && !inta_n_i;
        data_o    = data_oe_o ? (base_i + VW'(lock_q)) : '0;
    end
endmodule

// File: rtl/irq_ctl.sv
`timescale 1ns/1ps
// Module: irq_ctl (top)
// Eight-line interrupt controller: register file, priority resolver and
// acknowledge sequencer. Line 0 is the timer, line 2 the cascade request.
module irq_ctl #(
    parameter int N        = 8,
    parameter int VW       = 8,
    parameter int BASE_RST = 32,
    parameter int BASE_MIN = 32,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_i,
    input  logic          inta_n_i,
    input  logic          reg_we_i,
    input  logic [1:0]    reg_addr_i,
    input  logic [VW-1:0] reg_wdata_i,
    output logic [VW-1:0] reg_rdata_o,
    output logic          intr_o,
    output logic [VW-1:0] data_o,
    output logic          data_oe_o
);
    logic [N-1:0]  req_q, mask_q, isr_q, isr_set, pend;
    logic [VW-1:0] base_q;
    logic          win_valid;
    logic [IW-1:0] win_idx;

    // Unmasked pending requests feed the resolver.
    assign pend = req_q & ~mask_q;

    irq_regs #(.N(N), .VW(VW), .BASE_RST(BASE_RST), .BASE_MIN(BASE_MIN)) u_regs (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i),
        .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .isr_set_i(isr_set), .req_q(req_q), .mask_q(mask_q), .base_q(base_q),
        .isr_q(isr_q), .reg_rdata_o(reg_rdata_o)
    );

    irq_prio #(.N(N)) u_prio (
        .pend_i(pend), .isr_i(isr_q), .win_valid_o(win_valid), .win_idx_o(win_idx)
    );

    irq_ack_fsm #(.N(N), .VW(VW)) u_ack (
        .clk(clk), .rst_n(rst_n), .inta_n_i(inta_n_i),
        .win_valid_i(win_valid), .win_idx_i(win_idx), .base_i(base_q),
        .intr_o(intr_o), .isr_set_o(isr_set), .data_o(data_o), .data_oe_o(data_oe_o)
    );
endmodule

// File: rtl/irq_ctl_chk.sv
`timescale 1ns/1ps
// Module: irq_ctl_chk
// Property checker bound into irq_ctl; observes ports and register state.
module irq_ctl_chk #(
    parameter int N        = 8,
    parameter int VW       = 8,
    parameter int BASE_MIN = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          inta_n_i,
    input logic          intr_o,
    input logic [VW-1:0] data_o,
    input logic          data_oe_o,
    input logic [N-1:0]  req_q,
    input logic [N-1:0]  mask_q,
    input logic [N-1:0]  isr_q,
    input logic [VW-1:0] base_q,
    input logic          reg_we_i,
    input logic [1:0]    reg_addr_i,
    input logic [VW-1:0] reg_wdata_i
);
    localparam int BASE_MAX = (1 << VW) - N;

    assert_masked_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        intr_o |-> |(req_q & ~mask_q));

    assert_vector_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> (int'(data_o) >= BASE_MIN));

    assert_intr_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !inta_n_i |-> !intr_o);

    assert_eoi_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && reg_addr_i == 2'd2 && reg_wdata_i[N-1:0] == '1) |=> (isr_q == '0));

    assert_bus_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe_o |-> (data_o == '0));

    assert_drive_in_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> !inta_n_i);

    assert_base_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(base_q) >= BASE_MIN) && (int'(base_q) <= BASE_MAX));
endmodule

bind irq_ctl irq_ctl_chk #(.N(N), .VW(VW), .BASE_MIN(BASE_MIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .inta_n_i(inta_n_i), .intr_o(intr_o),
    .data_o(data_o), .data_oe_o(data_oe_o), .req_q(req_q), .mask_q(mask_q),
    .isr_q(isr_q), .base_q(base_q), .reg_we_i(reg_we_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i)
);

// File: tb/tb_irq_ctl.sv
`timescale 1ns/1ps
// Scoreboard bench: the acknowledge driver queues expected vectors, the
// monitor pops them whenever the bus is driven and checks an idle bus is zero.
module tb_irq_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq = '0;
    logic       inta_n = 1'b1;
    logic       we = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, data;
    logic       intr, oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    irq_ctl dut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .inta_n_i(inta_n),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .intr_o(intr), .data_o(data), .data_oe_o(oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        we = 1'b1; addr = a; wdata = d;
        tick();
        we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [1:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    // Driver: queue the expected vector, then run both acknowledge pulses.
    task automatic do_ack(input logic [7:0] exp_vec);
        exp_q.push_back(exp_vec);
        inta_n = 1'b0;
        tick();
        chk("R4 intr low in first pulse", {7'd0, intr}, 8'd0);
        inta_n = 1'b1;
        tick();
        chk("R4 intr low between pulses", {7'd0, intr}, 8'd0);
        inta_n = 1'b0;
        tick();
        inta_n = 1'b1;
        tick();
    endtask

    // Monitor: compare driven vectors with the queue; idle bus must be zero.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (oe) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R7 unexpected bus drive: actual %0h expected none", data);
                end else begin
                    chk("R3 vector on second pulse", data, exp_q.pop_front());
                end
            end else begin
                chk("R7 idle bus zero", data, 8'd0);
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired (all requirements): actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 intr after reset", {7'd0, intr}, 8'd0);
        chk("R1 oe after reset", {7'd0, oe}, 8'd0);
        chk("R1 data after reset", data, 8'd0);
        rd("R1 mask reset", 2'd0, 8'h00);
        rd("R1 base reset", 2'd1, 8'h20);
        rd("R1 isr reset", 2'd2, 8'h00);

        // R3 single request on line 3
        irq = 8'h08;
        tick();
        chk("R3 intr raised", {7'd0, intr}, 8'd1);
        do_ack(8'd35);
        rd("R5 isr set line 3", 2'd2, 8'h08);
        chk("R5 line 3 blocks itself", {7'd0, intr}, 8'd0);

        // R5 nesting: line 1 beats in-service line 3
        irq = 8'h0A;
        tick();
        chk("R5 higher line nests", {7'd0, intr}, 8'd1);
        do_ack(8'd33);
        rd("R5 isr two levels", 2'd2, 8'h0A);

        // R6 end-of-interrupt bit by bit
        irq = 8'h00;
        wr(2'd2, 8'h02);
        rd("R6 eoi line 1", 2'd2, 8'h08);
        wr(2'd2, 8'h08);
        rd("R6 eoi line 3", 2'd2, 8'h00);

        // R8 base range
        wr(2'd1, 8'h40);
        rd("R8 base accepted", 2'd1, 8'h40);
        wr(2'd1, 8'h10);
        rd("R8 low base ignored", 2'd1, 8'h40);
        wr(2'd1, 8'hF9);
        rd("R8 high base ignored", 2'd1, 8'h40);

        // R2 masking
        wr(2'd0, 8'hFF);
        irq = 8'hFF;
        tick();
        chk("R2 all masked silent", {7'd0, intr}, 8'd0);
        rd("R10 req sampled", 2'd3, 8'hFF);
        wr(2'd0, 8'h0F);
        chk("R2 unmasked upper lines raise", {7'd0, intr}, 8'd1);
        do_ack(8'h44);
        rd("R2 masked lines skipped", 2'd2, 8'h10);
        irq = 8'h00;
        wr(2'd2, 8'hFF);
        rd("R6 eoi all", 2'd2, 8'h00);

        // R9 acknowledge with nothing pending
        tick();
        chk("R9 no request idle", {7'd0, intr}, 8'd0);
        do_ack(8'h47);
        rd("R9 no isr set", 2'd2, 8'h00);

        // R10 request register, write ignored; R3 ordering line 2 over 5
        wr(2'd0, 8'h00);
        irq = 8'h24;
        tick();
        rd("R10 req readback", 2'd3, 8'h24);
        wr(2'd3, 8'h00);
        rd("R10 req write ignored", 2'd3, 8'h24);
        do_ack(8'h42);
        rd("R3 line 2 beats line 5", 2'd2, 8'h04);

        tick();
        chk("R3 scoreboard drained", 8'(exp_q.size()), 8'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule